// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block turns an asynchronous serial input line into parallel words. A one-cycle enable that fires sixteen times per bit period clocks its sampling. The word length, the parity mode and the stop-bit check are programmed through a few configuration inputs, which are shared with the companion transmitter. Each finished word is placed in a single holding register. Four status outputs report the state of the receiver: holding register full, overrun, framing error and parity error. An interrupt request is raised while the holding register is full and receive interrupts are enabled.

The host empties the holding register with a one-cycle data-read strobe and reads the status with a status-read strobe. A program-reset strobe puts the receiver and all of its flags back into their idle state without touching the global reset. When echo mode is selected, the raw receive line is routed to the serial transmit output in place of the transmitter's own serial stream.

Top module: `serial_rx_core`

## Requirements
- R1: After `rst_n` is deasserted, `rx_full`, `overrun`, `frame_err`, `parity_err` and `irq` are all 0.
- R2: A frame starts on a high-to-low change of the line seen on a tick. The start is confirmed only if the line is still low 8 ticks later. A low pulse shorter than that produces no word and changes no flag.
- R3: Data bits arrive least significant bit first. Each bit is sampled 16 ticks after the previous one. `word_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Every `rx_data` bit above the word length reads 0.
- R4: With `par_en`=1, one parity bit follows the data. `par_odd`=0 expects even parity and 1 expects odd parity. `parity_err` is set when the received parity does not match, and is rewritten with every frame. With `par_en`=0 it is written 0.
- R5: `frame_err` is set to the inverse of the first stop-bit sample, and is rewritten with every frame.
- R6: A finished frame sets `rx_full` and loads `rx_data`. A one-cycle `data_rd` clears `rx_full` on the next clock.
- R7: A frame that finishes while `rx_full`=1 sets `overrun` and leaves `rx_data` unchanged. `overrun` clears only on a `data_rd` that follows a `stat_rd` issued while `overrun` was set.
- R8: `irq` is 1 exactly when `rx_full`=1 and `rx_irq_en`=1.
- R9: With `echo_en`=1, `txd_out` equals `rxd`. With `echo_en`=0, `txd_out` equals `tx_serial`.
- R10: A one-cycle `prog_reset` clears `rx_full`, `overrun`, `frame_err` and `parity_err` on the next clock. It also abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| tx_serial | input | 1 | Serial stream from the transmitter |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| echo_en | input | 1 | Loop the receive line to the transmit output |
| rx_irq_en | input | 1 | Receive interrupt enable |
| prog_reset | input | 1 | Program reset strobe |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data read strobe |
| rx_data | output | 8 | Received word, zero extended |
| rx_full | output | 1 | Holding register holds unread data |
| overrun | output | 1 | A word was lost |
| frame_err | output | 1 | Last stop bit was low |
| parity_err | output | 1 | Last parity did not match |
| irq | output | 1 | Receive interrupt request |
| txd_out | output | 1 | Serial transmit output |

## Verification
On every cycle, the assertions check that the holding register and its data stay put until they are read, that overrun never moves the stored word, that the overrun flag is sticky, that program reset clears the flags, and that the interrupt follows the full flag. Only the bench scenarios can show the frame-level behaviour: bit order and length for each word size, a good and a bad parity result, a low stop bit, a rejected start glitch, the status-then-data order that clears overrun, and a reset that cuts a frame short. The bench's reference model is updated per frame and per strobe, and it is compared with the ports on every clock.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int CNT_W  = $clog2(OSR);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              line_i,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o,
    output logic              perr_o,
    output logic              ferr_o
);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              pacc;
        logic              last;
        logic [1:0]        sync;
        logic              done;
        logic [DATA_W-1:0] word;
        logic              perr;
        logic              ferr;
    } frame_s;

    localparam frame_s FRAME_RST = '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0,
                                     pacc: 1'b0, last: 1'b1, sync: 2'b11,
                                     done: 1'b0, word: '0, perr: 1'b0,
                                     ferr: 1'b0};

    frame_s s_d, s_q;

    logic [IDX_W:0]    nbits;
    logic              smp;
    logic [DATA_W-1:0] sh_in;

    assign nbits = (IDX_W+1)'(MIN_BITS) + (IDX_W+1)'(word_len);
    assign smp   = s_q.sync[1];
    assign sh_in = {smp, s_q.sh[DATA_W-1:1]};

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], line_i};
        if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    s_d.last = smp;
                    if (s_q.last && !smp) begin
                        s_d.st  = RX_START;
                        s_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.cnt == MID_CNT) begin
                        s_d.cnt  = '0;
                        s_d.idx  = '0;
                        s_d.pacc = 1'b0;
                        if (!smp) begin
                            s_d.st = RX_DATA;
                        end else begin
                            s_d.st   = RX_IDLE;
                            s_d.last = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt  = '0;
                        s_d.sh   = sh_in;
                        s_d.pacc = s_q.pacc ^ smp;
                        if ({1'b0, s_q.idx} == nbits - 1'b1) begin
                            s_d.st = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt  = '0;
                        s_d.pacc = s_q.pacc ^ smp;
                        s_d.st   = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.cnt  = '0;
                        s_d.done = 1'b1;
                        s_d.ferr = !smp;
                        s_d.perr = par_en && (s_q.pacc != par_odd);
                        s_d.word = s_q.sh >> (DATA_W - int'(nbits));
                        s_d.st   = RX_IDLE;
                        s_d.last = smp;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
        if (clr) begin
            s_d      = FRAME_RST;
            s_d.sync = {s_q.sync[0], line_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FRAME_RST;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign word_o = s_q.word;
    assign perr_o = s_q.perr;
    assign ferr_o = s_q.ferr;
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              done_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              ferr_o,
    output logic              perr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              armed;
        logic              ferr;
        logic              perr;
    } regs_s;

    localparam regs_s REGS_RST = '{data: '0, full: 1'b0, ovr: 1'b0,
                                   armed: 1'b0, ferr: 1'b0, perr: 1'b0};

    regs_s r_d, r_q;
    logic  still_full;

    assign still_full = r_q.full && !data_rd;

    always_comb begin
        r_d = r_q;
        if (data_rd) begin
            r_d.full = 1'b0;
            if (r_q.armed) begin
                r_d.ovr   = 1'b0;
                r_d.armed = 1'b0;
            end
        end
        if (stat_rd && r_q.ovr && !(data_rd && r_q.armed)) begin
            r_d.armed = 1'b1;
        end
        if (done_i) begin
            r_d.ferr = ferr_i;
            r_d.perr = perr_i;
            if (still_full) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data = word_i;
                r_d.full = 1'b1;
            end
        end
        if (clr) r_d = REGS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign data_o = r_q.data;
    assign full_o = r_q.full;
    assign ovr_o  = r_q.ovr;
    assign ferr_o = r_q.ferr;
    assign perr_o = r_q.perr;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              tx_serial,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              echo_en,
    input  logic              rx_irq_en,
    input  logic              prog_reset,
    input  logic              stat_rd,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              frame_err,
    output logic              parity_err,
    output logic              irq,
    output logic              txd_out
);
    logic              f_done;
    logic [DATA_W-1:0] f_word;
    logic              f_perr;
    logic              f_ferr;

    serial_rx_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (prog_reset),
        .tick     (tick16),
        .line_i   (rxd),
        .word_len (word_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .done_o   (f_done),
        .word_o   (f_word),
        .perr_o   (f_perr),
        .ferr_o   (f_ferr)
    );

    serial_rx_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (prog_reset),
        .done_i  (f_done),
        .word_i  (f_word),
        .perr_i  (f_perr),
        .ferr_i  (f_ferr),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .data_o  (rx_data),
        .full_o  (rx_full),
        .ovr_o   (overrun),
        .ferr_o  (frame_err),
        .perr_o  (parity_err)
    );

    assign irq     = rx_full && rx_irq_en;
    assign txd_out = echo_en ? rxd : tx_serial;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] word_len,
    input logic       rx_irq_en,
    input logic       prog_reset,
    input logic       data_rd,
    input logic [7:0] rx_data,
    input logic       rx_full,
    input logic       overrun,
    input logic       frame_err,
    input logic       parity_err,
    input logic       irq
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        prog_reset |=> !rx_full && !overrun && !frame_err && !parity_err); // R10

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !data_rd && !prog_reset |=> rx_full); // R6

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !data_rd && !prog_reset |=> $stable(rx_data)); // R7

    AST_OVR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data)); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !data_rd && !prog_reset |=> overrun); // R7

    AST_SHORT_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) && word_len == 2'd0 |-> rx_data[7:5] == 3'b000); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_full && rx_irq_en); // R8
endmodule

bind serial_rx_core serial_rx_core_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_len   (word_len),
    .rx_irq_en  (rx_irq_en),
    .prog_reset (prog_reset),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .overrun    (overrun),
    .frame_err  (frame_err),
    .parity_err (parity_err),
    .irq        (irq)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       tx_serial = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       echo_en = 1'b0;
    logic       rx_irq_en = 1'b1;
    logic       prog_reset = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, frame_err, parity_err, irq, txd_out;

    int checks = 0;
    int failures = 0;
    bit done_flag = 1'b0;
    bit cmp_en = 1'b0;

    // reference model state
    bit       m_full = 0, m_ovr = 0, m_armed = 0, m_fe = 0, m_pe = 0;
    bit [7:0] m_data = 0;

    always #2.5 clk = ~clk;

    serial_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .tx_serial(tx_serial), .word_len(word_len), .par_en(par_en),
        .par_odd(par_odd), .echo_en(echo_en), .rx_irq_en(rx_irq_en),
        .prog_reset(prog_reset), .stat_rd(stat_rd), .data_rd(data_rd),
        .rx_data(rx_data), .rx_full(rx_full), .overrun(overrun),
        .frame_err(frame_err), .parity_err(parity_err), .irq(irq),
        .txd_out(txd_out)
    );

    // tick every 4th clock
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv   = (tdiv + 1) % 4;
        tick16 <= (tdiv == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(txd_out == (echo_en ? rxd : tx_serial), "R9", txd_out, echo_en ? rxd : tx_serial);
            if (cmp_en) begin
                chk(rx_full == m_full, "R6", rx_full, m_full);
                chk(overrun == m_ovr, "R7", overrun, m_ovr);
                chk(frame_err == m_fe, "R5", frame_err, m_fe);
                chk(parity_err == m_pe, "R4", parity_err, m_pe);
                chk(irq == (m_full && rx_irq_en), "R8", irq, m_full && rx_irq_en);
                if (m_full) chk(rx_data == m_data, "R3", rx_data, m_data);
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
        #1;
    endtask

    task automatic line_bit(input bit b);
        rxd = b;
        wait_ticks(16);
    endtask

    task automatic send_frame(input bit [7:0] d, input bit flip_par, input bit stop);
        int  nb;
        bit [7:0] dm;
        bit  p;
        nb = 5 + int'(word_len);
        dm = d & 8'((1 << nb) - 1);
        cmp_en = 0;
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(dm[i]);
        p = (^dm) ^ par_odd ^ flip_par;
        if (par_en) line_bit(p);
        line_bit(stop);
        rxd = 1'b1;
        wait_ticks(32);
        m_fe = !stop;
        m_pe = par_en && flip_par;
        if (m_full) m_ovr = 1;
        else begin
            m_data = dm;
            m_full = 1;
        end
        cmp_en = 1;
    endtask

    task automatic rd_data();
        @(negedge clk);
        data_rd = 1;
        @(posedge clk);
        #1;
        m_full = 0;
        if (m_armed) begin
            m_ovr = 0;
            m_armed = 0;
        end
        @(negedge clk);
        data_rd = 0;
    endtask

    task automatic rd_stat();
        @(negedge clk);
        stat_rd = 1;
        @(posedge clk);
        #1;
        if (m_ovr) m_armed = 1;
        @(negedge clk);
        stat_rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!rx_full && !overrun && !frame_err && !parity_err && !irq, "R1",
            {rx_full, overrun, frame_err, parity_err, irq}, 0);
        cmp_en = 1;
        repeat (40) @(negedge clk);

        // R3 R6 R8: 8-bit word, no parity
        send_frame(8'hA5, 0, 1);
        chk(rx_data == 8'hA5, "R3", rx_data, 8'hA5);
        chk(irq == 1, "R8", irq, 1);
        rx_irq_en = 0;
        @(negedge clk);
        chk(irq == 0, "R8", irq, 0);
        rx_irq_en = 1;
        rd_data();
        @(negedge clk);
        chk(rx_full == 0, "R6", rx_full, 0);

        // R4: 7-bit even parity, good
        word_len = 2'd2; par_en = 1; par_odd = 0;
        send_frame(8'hDA, 0, 1);
        chk(rx_data == 8'h5A && !parity_err, "R4", rx_data, 8'h5A);
        rd_data();

        // R3 R4: 5-bit odd parity, bad parity, upper bits zero
        word_len = 2'd0; par_odd = 1;
        send_frame(8'hFF, 1, 1);
        chk(rx_data == 8'h1F, "R3", rx_data, 8'h1F);
        chk(parity_err == 1, "R4", parity_err, 1);
        rd_data();
        send_frame(8'h0B, 0, 1);
        chk(parity_err == 0, "R4", parity_err, 0);
        rd_data();

        // R5: 6-bit word with low stop bit, then recovery
        word_len = 2'd1; par_en = 0;
        send_frame(8'h2C, 0, 0);
        chk(frame_err == 1, "R5", frame_err, 1);
        chk(rx_data == 8'h2C, "R3", rx_data, 8'h2C);
        rd_data();
        send_frame(8'h13, 0, 1);
        chk(frame_err == 0, "R5", frame_err, 0);
        rd_data();

        // R7: overrun keeps old data, clears only after status then data read
        word_len = 2'd3;
        send_frame(8'h3C, 0, 1);
        send_frame(8'hC3, 0, 1);
        chk(overrun == 1 && rx_data == 8'h3C, "R7", rx_data, 8'h3C);
        rd_data();
        @(negedge clk);
        chk(overrun == 1, "R7", overrun, 1);
        rd_stat();
        rd_data();
        @(negedge clk);
        chk(overrun == 0, "R7", overrun, 0);

        // R2: short low glitch rejected, then a real frame still works
        rxd = 0;
        wait_ticks(4);
        rxd = 1;
        wait_ticks(64);
        chk(rx_full == 0, "R2", rx_full, 0);
        send_frame(8'h81, 0, 1);
        chk(rx_data == 8'h81, "R2", rx_data, 8'h81);

        // R9: echo during a frame
        echo_en = 1;
        rd_data();
        send_frame(8'h66, 0, 1);
        echo_en = 0;
        tx_serial = 1;
        @(negedge clk);
        chk(txd_out == 1, "R9", txd_out, 1);

        // R10: program reset clears flags and abandons a frame in progress
        send_frame(8'h99, 0, 0);
        chk(rx_full && frame_err && overrun, "R10", {rx_full, frame_err, overrun}, 7);
        cmp_en = 0;
        rxd = 0;
        wait_ticks(16);
        rxd = 1;
        wait_ticks(20);
        @(negedge clk);
        prog_reset = 1;
        @(negedge clk);
        prog_reset = 0;
        chk(!rx_full && !overrun && !frame_err && !parity_err, "R10",
            {rx_full, overrun, frame_err, parity_err}, 0);
        m_full = 0; m_ovr = 0; m_armed = 0; m_fe = 0; m_pe = 0;
        cmp_en = 1;
        wait_ticks(200);
        chk(rx_full == 0, "R10", rx_full, 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule